// File: doc/BRIEF.md
# Privileged Status and Stack Unit

This unit keeps a processor's 16-bit status word and a pair of 32-bit stack pointers, one for user state and one for supervisor state. A single stack-pointer port reaches whichever pointer the supervisor bit currently selects. The unit also filters status-word writes by privilege, and it turns privileged requests made in user state into a violation pulse. A pipeline drives it from decode and execute. ALU flag results come in with a per-flag enable. Exception entry and return strobes switch the privilege state, and the old status word is handed out for stacking.

A 4-bit condition selector is evaluated combinationally against the current flags. It yields a branch-taken result and an invalid indication for the two constant conditions when the selector is used in branch mode.

Top module: `priv_status_unit`

## Requirements
- R1: After a synchronous reset the status word reads 0x2700: supervisor state, trace clear, interrupt mask 7. Both stack pointers read zero, and the violation, grant and saved-word outputs are zero.
- R2: Bits 5, 6, 7, 11, 12 and 14 of the status word always read zero, whatever is written or restored.
- R3: Condition codes sit at C bit 0, V bit 1, Z bit 2, N bit 3 and X bit 4. A status write in user state (bit 13 = 0) changes only these five bits. Bits 15..8 keep their value.
- R4: A status write in supervisor state updates the trace bit 15, supervisor bit 13 and mask bits 10..8 as well as the condition codes.
- R5: The stack port reads and writes the user pointer when bit 13 is 0 and the supervisor pointer when it is 1. The other pointer is unchanged by that write.
- R6: A privileged request in supervisor state gives a one-cycle grant pulse on the next cycle. In user state it gives a one-cycle violation pulse instead and no grant.
- R7: The flag-update input writes each of X, N, Z, V, C only where its enable bit (same bit positions) is set.
- R8: The condition result follows the selector encoding T=0, F=1, HI=2, LS=3, CC=4, CS=5, NE=6, EQ=7, VC=8, VS=9, PL=10, MI=11, GE=12, LT=13, GT=14, LE=15, with the usual flag equations (T true, F false).
- R9: The invalid output is high exactly when branch mode is set and the selector is 0 or 1.
- R10: Exception entry outputs the old status word on the next cycle. It also sets bit 13 and clears bit 15 in that cycle, and leaves the other bits unchanged.
- R11: Exception return loads the whole supplied status word, reserved bits forced to zero, so the stack port can fall back to the user pointer.
- R12: When several updates coincide, entry wins over return, return over a status write, and a status write over a flag update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_wr_en | input | 1 | Status word write strobe |
| sr_wr_data | input | 16 | Status word write value |
| flag_we | input | 5 | Per-flag write enables, bit 4 X .. bit 0 C |
| flag_in | input | 5 | New flag values, same positions |
| exc_enter | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Return-from-exception strobe |
| exc_restore_sr | input | 16 | Status word restored on return |
| exc_saved_sr | output | 16 | Status word captured at the last entry |
| priv_req | input | 1 | Privileged operation request |
| priv_grant | output | 1 | Registered grant pulse |
| priv_viol | output | 1 | Registered privilege violation pulse |
| a7_wr_en | input | 1 | Stack pointer write strobe |
| a7_wr_data | input | SP_W | Stack pointer write value |
| a7_rd_data | output | SP_W | Active stack pointer |
| sr_q | output | 16 | Current status word |
| cond_sel | input | 4 | Condition selector |
| cond_branch_mode | input | 1 | Selector used for a branch |
| cond_true | output | 1 | Condition result |
| cond_invalid | output | 1 | Constant condition used in branch mode |

## Verification
The bench builds the unit with SP_W = 32 and RST_IMASK = 7, the widths the status format assumes. Full-width random pointer values then show that the two banks never leak into each other. The mask value leaves reset's 0x2700 word as an exact target. Random traffic that flips the supervisor bit through writes, entries and returns reaches both banks and both privilege outcomes. Directed cases cover coincident updates and reserved-bit writes.

// File: rtl/status_pkg.sv
package status_pkg;
  localparam int SRW     = 16;
  localparam int B_C     = 0;
  localparam int B_V     = 1;
  localparam int B_Z     = 2;
  localparam int B_N     = 3;
  localparam int B_X     = 4;
  localparam int B_S     = 13;
  localparam int B_T     = 15;
  localparam int NFLAG   = 5;
  localparam logic [SRW-1:0] SR_VALID = 16'hA71F;
  localparam logic [SRW-1:0] CC_VALID = 16'h001F;

  typedef enum logic [3:0] {
    C_T = 4'd0, C_F = 4'd1, C_HI = 4'd2, C_LS = 4'd3,
    C_CC = 4'd4, C_CS = 4'd5, C_NE = 4'd6, C_EQ = 4'd7,
    C_VC = 4'd8, C_VS = 4'd9, C_PL = 4'd10, C_MI = 4'd11,
    C_GE = 4'd12, C_LT = 4'd13, C_GT = 4'd14, C_LE = 4'd15
  } cond_e;
endpackage

// File: rtl/sr_reg.sv
module sr_reg
  import status_pkg::*;
#(
  parameter logic [2:0] RST_IMASK = 3'd7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SRW-1:0]   wr_data,
  input  logic [NFLAG-1:0] flag_we,
  input  logic [NFLAG-1:0] flag_in,
  input  logic             exc_enter,
  input  logic             exc_return,
  input  logic [SRW-1:0]   restore,
  output logic [SRW-1:0]   sr_q,
  output logic [SRW-1:0]   saved_q
);
  localparam logic [SRW-1:0] RST_SR = (SRW'(1) << B_S) | (SRW'(RST_IMASK) << 8);

  logic [SRW-1:0] sr_d;
  logic [SRW-1:0] wmask;

  always_comb begin
    wmask = sr_q[B_S] ? SR_VALID : CC_VALID;
    sr_d  = sr_q;
    if (exc_enter) begin
      sr_d[B_S] = 1'b1;
      sr_d[B_T] = 1'b0;
    end else if (exc_return) begin
      sr_d = restore & SR_VALID;
    end else if (wr_en) begin
      sr_d = (sr_q & ~wmask) | (wr_data & wmask);
    end else begin
      for (int i = 0; i < NFLAG; i++)
        if (flag_we[i]) sr_d[i] = flag_in[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q    <= RST_SR;
      saved_q <= '0;
    end else begin
      sr_q <= sr_d;
      if (exc_enter) saved_q <= sr_q;
    end
  end

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (sr_q & ~SR_VALID) == '0);
  a_r3_user_sysbyte_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sr_q[B_S] && !exc_enter && !exc_return) |=> sr_q[15:8] == $past(sr_q[15:8]));
  a_r10_entry_state: assert property (@(posedge clk) disable iff (rst)
    exc_enter |=> (sr_q[B_S] && !sr_q[B_T] && saved_q == $past(sr_q)));
endmodule

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int SP_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sup,
  input  logic            wr_en,
  input  logic [SP_W-1:0] wr_data,
  output logic [SP_W-1:0] rd_data
);
  logic [SP_W-1:0] usp_q, ssp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      usp_q <= '0;
      ssp_q <= '0;
    end else if (wr_en) begin
      if (sup) ssp_q <= wr_data;
      else     usp_q <= wr_data;
    end
  end

  assign rd_data = sup ? ssp_q : usp_q;

  a_r5_user_write_keeps_ssp: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sup) |=> $stable(ssp_q));
  a_r5_sup_write_keeps_usp: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sup) |=> $stable(usp_q));
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import status_pkg::*;
(
  input  logic [3:0] flags,
  input  logic [3:0] sel,
  input  logic       branch_mode,
  output logic       result,
  output logic       invalid
);
  logic n, z, v, c;
  assign {n, z, v, c} = flags;

  always_comb begin
    case (cond_e'(sel))
      C_T:  result = 1'b1;
      C_F:  result = 1'b0;
      C_HI: result = !c && !z;
      C_LS: result = c || z;
      C_CC: result = !c;
      C_CS: result = c;
      C_NE: result = !z;
      C_EQ: result = z;
      C_VC: result = !v;
      C_VS: result = v;
      C_PL: result = !n;
      C_MI: result = n;
      C_GE: result = (n == v);
      C_LT: result = (n != v);
      C_GT: result = (n == v) && !z;
      default: result = z || (n != v);
    endcase
  end

  assign invalid = branch_mode && (sel[3:1] == 3'b000);
endmodule

// File: rtl/priv_status_unit.sv
module priv_status_unit
  import status_pkg::*;
#(
  parameter int         SP_W      = 32,
  parameter logic [2:0] RST_IMASK = 3'd7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sr_wr_en,
  input  logic [15:0]      sr_wr_data,
  input  logic [4:0]       flag_we,
  input  logic [4:0]       flag_in,
  input  logic             exc_enter,
  input  logic             exc_return,
  input  logic [15:0]      exc_restore_sr,
  output logic [15:0]      exc_saved_sr,
  input  logic             priv_req,
  output logic             priv_grant,
  output logic             priv_viol,
  input  logic             a7_wr_en,
  input  logic [SP_W-1:0]  a7_wr_data,
  output logic [SP_W-1:0]  a7_rd_data,
  output logic [15:0]      sr_q,
  input  logic [3:0]       cond_sel,
  input  logic             cond_branch_mode,
  output logic             cond_true,
  output logic             cond_invalid
);
  logic sup;

  sr_reg #(.RST_IMASK(RST_IMASK)) u_sr (
    .clk(clk), .rst(rst),
    .wr_en(sr_wr_en), .wr_data(sr_wr_data),
    .flag_we(flag_we), .flag_in(flag_in),
    .exc_enter(exc_enter), .exc_return(exc_return),
    .restore(exc_restore_sr),
    .sr_q(sr_q), .saved_q(exc_saved_sr)
  );

  assign sup = sr_q[B_S];

  sp_bank #(.SP_W(SP_W)) u_sp (
    .clk(clk), .rst(rst), .sup(sup),
    .wr_en(a7_wr_en), .wr_data(a7_wr_data), .rd_data(a7_rd_data)
  );

  cond_eval u_cond (
    .flags(sr_q[3:0]), .sel(cond_sel), .branch_mode(cond_branch_mode),
    .result(cond_true), .invalid(cond_invalid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      priv_grant <= 1'b0;
      priv_viol  <= 1'b0;
    end else begin
      priv_grant <= priv_req && sup;
      priv_viol  <= priv_req && !sup;
    end
  end

  a_r6_user_violates: assert property (@(posedge clk) disable iff (rst)
    (priv_req && !sup) |=> (priv_viol && !priv_grant));
  a_r6_sup_grants: assert property (@(posedge clk) disable iff (rst)
    (priv_req && sup) |=> (priv_grant && !priv_viol));
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !priv_req |=> (!priv_grant && !priv_viol));
  a_r9_invalid_only_in_branch: assert property (@(posedge clk) disable iff (rst)
    cond_invalid |-> cond_branch_mode);
endmodule

// File: tb/priv_status_unit_tb.sv
module priv_status_unit_tb_top;
  localparam int CLK_P = 10;
  localparam int SP_W  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sr_wr_en = 0; logic [15:0] sr_wr_data = 0;
  logic [4:0] flag_we = 0, flag_in = 0;
  logic exc_enter = 0, exc_return = 0; logic [15:0] exc_restore_sr = 0;
  logic [15:0] exc_saved_sr;
  logic priv_req = 0, priv_grant, priv_viol;
  logic a7_wr_en = 0; logic [SP_W-1:0] a7_wr_data = 0, a7_rd_data;
  logic [15:0] sr_q;
  logic [3:0] cond_sel = 0; logic cond_branch_mode = 0;
  logic cond_true, cond_invalid;

  always #(CLK_P/2) clk = ~clk;

  priv_status_unit #(.SP_W(SP_W), .RST_IMASK(3'd7)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_sr, m_saved;
  logic [SP_W-1:0] m_usp, m_ssp;
  logic m_grant, m_viol;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic cond_ref(logic [15:0] s, logic [3:0] sel);
    logic n, z, v, c;
    {n, z, v, c} = s[3:0];
    case (sel)
      0: return 1; 1: return 0;
      2: return !c & !z; 3: return c | z;
      4: return !c; 5: return c; 6: return !z; 7: return z;
      8: return !v; 9: return v; 10: return !n; 11: return n;
      12: return n == v; 13: return n != v;
      14: return (n == v) & !z;
      default: return z | (n != v);
    endcase
  endfunction

  task automatic idle();
    sr_wr_en = 0; flag_we = 0; exc_enter = 0; exc_return = 0;
    priv_req = 0; a7_wr_en = 0;
  endtask

  task automatic model_step();
    logic [15:0] wm;
    logic [15:0] nsr;
    m_grant = priv_req & m_sr[13];
    m_viol  = priv_req & !m_sr[13];
    if (a7_wr_en) begin
      if (m_sr[13]) m_ssp = a7_wr_data; else m_usp = a7_wr_data;
    end
    nsr = m_sr;
    wm = m_sr[13] ? 16'hA71F : 16'h001F;
    if (exc_enter) begin
      m_saved = m_sr; nsr[13] = 1; nsr[15] = 0;
    end else if (exc_return) nsr = exc_restore_sr & 16'hA71F;
    else if (sr_wr_en) nsr = (m_sr & ~wm) | (sr_wr_data & wm);
    else for (int i = 0; i < 5; i++) if (flag_we[i]) nsr[i] = flag_in[i];
    m_sr = nsr;
  endtask

  task automatic check_all();
    chk("R7 status", {16'h0, sr_q}, {16'h0, m_sr});
    chk("R5 a7", a7_rd_data, m_sr[13] ? m_ssp : m_usp);
    chk("R6 grant/viol", {30'h0, priv_grant, priv_viol}, {30'h0, m_grant, m_viol});
    chk("R10 saved", {16'h0, exc_saved_sr}, {16'h0, m_saved});
    chk("R8 cond", {31'h0, cond_true}, {31'h0, cond_ref(m_sr, cond_sel)});
    chk("R9 invalid", {31'h0, cond_invalid},
        {31'h0, cond_branch_mode && (cond_sel < 2)});
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
    idle();
  endtask

  logic done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    m_sr = 16'h2700; m_saved = 0; m_usp = 0; m_ssp = 0; m_grant = 0; m_viol = 0;
    // R1 reset state
    chk("R1 sr", {16'h0, sr_q}, 32'h2700);
    chk("R1 a7", a7_rd_data, 0);
    chk("R1 pulses", {30'h0, priv_grant, priv_viol}, 0);
    chk("R1 saved", {16'h0, exc_saved_sr}, 0);
    // R4 supervisor write full word, R2 reserved bits
    sr_wr_en = 1; sr_wr_data = 16'hFFFF; tick();
    chk("R2 reserved", {16'h0, sr_q}, 32'hA71F);
    a7_wr_en = 1; a7_wr_data = 32'hCAFE0000; tick();
    sr_wr_en = 1; sr_wr_data = 16'h0005; tick();
    chk("R4 sup write", {16'h0, sr_q}, 32'h0005);
    // R3 user write cannot raise system byte
    sr_wr_en = 1; sr_wr_data = 16'hA70A; tick();
    chk("R3 user write", {16'h0, sr_q}, 32'h000A);
    // R5 user bank
    a7_wr_en = 1; a7_wr_data = 32'h00001234; tick();
    chk("R5 usp", a7_rd_data, 32'h00001234);
    // R6 violation in user
    priv_req = 1; tick();
    chk("R6 viol", {31'h0, priv_viol}, 1);
    tick();
    chk("R6 pulse one cycle", {31'h0, priv_viol}, 0);
    // R12 entry beats write; R10 saved
    exc_enter = 1; sr_wr_en = 1; sr_wr_data = 16'h0000; tick();
    chk("R12 entry wins", {16'h0, sr_q}, 32'h200A);
    chk("R10 saved", {16'h0, exc_saved_sr}, 32'h000A);
    chk("R5 ssp", a7_rd_data, 32'hCAFE0000);
    // R11 return restores user, masked
    exc_return = 1; exc_restore_sr = 16'h58E3; tick();
    chk("R11 return", {16'h0, sr_q}, 32'h0003);
    chk("R11 back to usp", a7_rd_data, 32'h00001234);
    // R7 per-flag enable, R12 write beats flags
    flag_we = 5'b10100; flag_in = 5'b11111; tick();
    chk("R7 flags", {16'h0, sr_q}, 32'h0017);
    sr_wr_en = 1; sr_wr_data = 16'h0001; flag_we = 5'b11111; flag_in = 0; tick();
    chk("R12 write beats flags", {16'h0, sr_q}, 32'h0001);
    // R9 directed
    cond_branch_mode = 1; cond_sel = 1; #1;
    chk("R9 F invalid", {31'h0, cond_invalid}, 1);
    cond_sel = 2; #1;
    chk("R9 HI valid", {31'h0, cond_invalid}, 0);
    for (int s = 0; s < 16; s++) begin
      cond_sel = 4'(s); #1;
      chk("R8 sweep", {31'h0, cond_true}, {31'h0, cond_ref(m_sr, 4'(s))});
    end
    // random phase
    for (int k = 0; k < 4000; k++) begin
      sr_wr_en = ($urandom % 6) == 0;
      sr_wr_data = 16'($urandom);
      flag_we = 5'($urandom); flag_in = 5'($urandom);
      exc_enter = ($urandom % 12) == 0;
      exc_return = ($urandom % 10) == 0;
      exc_restore_sr = 16'($urandom);
      priv_req = ($urandom % 4) == 0;
      a7_wr_en = ($urandom % 3) == 0;
      a7_wr_data = $urandom;
      cond_sel = 4'($urandom); cond_branch_mode = 1'($urandom);
      tick();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule